// File: doc/BRIEF.md
# Priority interrupt controller with in-service tracking

This controller sits beside a small processor core and arbitrates among a set of interrupt sources. Each source has one byte-wide control register. The register holds a pending flag, a disable (mask) bit and a priority value. A peripheral sets a source's pending flag with a one-cycle pulse. Software can also set or clear the flag through the byte bus. Priority 0 is the most urgent level.

Nesting is tracked per priority level in an in-service register that has one bit per level. The controller forwards a request only from a source that is pending, unmasked and strictly more urgent than every level already in service. It presents the source index and level of that request to the core. When the core acknowledges, the controller clears the source's pending flag and marks the level as in service.

A return pulse from the core retires only the most urgent in-service level. The pulse has this effect only when both status inputs are low: the exception-state input and the non-maskable-state input. Software can therefore retire a level itself, and a later real return in the exception state leaves the register unchanged. Non-maskable interrupts never touch the in-service register.

Top module: `prio_intc`

## Requirements
- R1: After reset the in-service register is zero, every pending flag is 0, every mask bit is 1, every priority is 0, and `core_req` is low.
- R2: The control register of source i is at byte address `CTRL_BASE + 2*i`. Bit 7 is the pending flag, bit 6 is the mask and bits [2:0] hold the priority, with 0 the most urgent. Other bits read 0. Odd and unmapped addresses read 0.
- R3: A pulse on `src_pulse[i]` sets pending flag i. A bus write loads the flag, the mask and the priority. When a pulse and a clearing event for the same flag fall in the same cycle, the pulse wins.
- R4: A source whose mask bit is 1 is never forwarded, even when its flag is set.
- R5: Among the eligible sources the smallest priority value wins, and a tie goes to the lowest source index. `core_vec` and `core_lvl` give the winner. When `core_req` is low they read 0.
- R6: A source is not forwarded while the in-service bit of its own level, or of any more urgent level, is set.
- R7: An acknowledge while `core_req` is high clears the pending flag of the granted source and sets the in-service bit of its level on the same clock edge. An acknowledge while `core_req` is low changes nothing.
- R8: A return pulse with `psw_ep` and `psw_np` both low clears only the lowest-index (most urgent) set in-service bit. If either input is high, the in-service register is left unchanged.
- R9: The in-service register reads back at `ISPR_ADDR`, and bus writes to that address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NSRC | Per-source request pulses |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| core_req | output | 1 | Interrupt request to the core |
| core_vec | output | SW | Granted source index |
| core_lvl | output | PW | Granted priority level |
| core_ack | input | 1 | Core accepts the request |
| reti_pulse | input | 1 | Return-from-interrupt event |
| psw_ep | input | 1 | Core is in exception state |
| psw_np | input | 1 | Core is handling a non-maskable interrupt |

## Verification
The properties assume the core raises `core_ack` only as a single-cycle pulse. They also assume the return pulse and the status inputs are held stable around a clock edge. They do not assume that acknowledge and return are exclusive: the checks on return apply only in cycles without an accepted acknowledge. The stimulus drives every input one time unit after a rising edge and holds it for a whole cycle. It sends acknowledge and return pulses one at a time, and it sends an acknowledge while no request is pending only on purpose, to exercise R7.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC      = 8,
  parameter int NLVL      = 8,
  parameter int AW        = 8,
  parameter int CTRL_BASE = 'h10,
  parameter int ISPR_ADDR = 'hFA,
  localparam int PW = $clog2(NLVL),
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            core_req,
  output logic [SW-1:0]   core_vec,
  output logic [PW-1:0]   core_lvl,
  input  logic            core_ack,
  input  logic            reti_pulse,
  input  logic            psw_ep,
  input  logic            psw_np
);

  logic [NSRC-1:0] pend, mask, elig;
  logic [PW-1:0]   prio [NSRC];
  logic [NLVL-1:0] ispr, blk, ret_bit;
  logic            ack_go, ret_go;
  logic            found;
  logic [PW-1:0]   best_p;
  logic [SW-1:0]   best_i;

  assign ack_go  = core_ack & core_req;
  assign ret_go  = reti_pulse & ~psw_ep & ~psw_np;
  assign ret_bit = ispr & (~ispr + NLVL'(1));

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [AW-1:0] A = AW'(CTRL_BASE + 2 * i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        mask[i] <= 1'b1;
        prio[i] <= '0;
      end else begin
        if (bus_we && bus_addr == A) begin
          pend[i] <= bus_wdata[7];
          mask[i] <= bus_wdata[6];
          prio[i] <= bus_wdata[PW-1:0];
        end else if (ack_go && core_vec == SW'(i)) begin
          pend[i] <= 1'b0;
        end
        if (src_pulse[i]) pend[i] <= 1'b1;
      end
    end
    assign elig[i] = pend[i] & ~mask[i] & ~blk[prio[i]];
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int l = 0; l < NLVL; l++) begin
      acc    = acc | ispr[l];
      blk[l] = acc;
    end
  end

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++)
      if (elig[i] && (!found || prio[i] < best_p)) begin
        found  = 1'b1;
        best_p = prio[i];
        best_i = SW'(i);
      end
  end

  assign core_req = found;
  assign core_vec = best_i;
  assign core_lvl = best_p;

  always_ff @(posedge clk) begin
    if (!rst_n) ispr <= '0;
    else ispr <= (ispr & ~(ret_go ? ret_bit : '0))
               | (ack_go ? (NLVL'(1) << core_lvl) : '0);
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == AW'(ISPR_ADDR)) bus_rdata = 8'(ispr);
    for (int i = 0; i < NSRC; i++)
      if (bus_addr == AW'(CTRL_BASE + 2 * i))
        bus_rdata = {pend[i], mask[i], 6'(prio[i])};
  end

endmodule

module prio_intc_chk #(
  parameter int NSRC = 8,
  parameter int NLVL = 8,
  parameter int PW   = 3,
  parameter int SW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_req,
  input logic [SW-1:0]   core_vec,
  input logic [PW-1:0]   core_lvl,
  input logic            core_ack,
  input logic            reti_pulse,
  input logic            psw_ep,
  input logic            psw_np,
  input logic [NLVL-1:0] ispr,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] mask
);
  logic took;
  assign took = core_req & core_ack;

  a_r6_outranks: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (ispr & ((NLVL'(2) << core_lvl) - NLVL'(1))) == '0);

  a_r4_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (!mask[core_vec] && pend[core_vec]));

  a_r7_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> ispr[$past(core_lvl)]);

  a_r7_no_ack_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> (ispr | $past(ispr)) == $past(ispr));

  a_r8_ret_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_pulse && (psw_ep || psw_np) && !took) |=> ispr == $past(ispr));

  a_r8_ret_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_pulse && !psw_ep && !psw_np && ispr != '0 && !took)
      |=> $countones(ispr) + 1 == $past($countones(ispr)));
endmodule

bind prio_intc prio_intc_chk #(.NSRC(NSRC), .NLVL(NLVL), .PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_vec(core_vec),
  .core_lvl(core_lvl), .core_ack(core_ack), .reti_pulse(reti_pulse),
  .psw_ep(psw_ep), .psw_np(psw_np), .ispr(ispr), .pend(pend), .mask(mask)
);

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_pulse = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       core_req;
  logic [2:0] core_vec, core_lvl;
  logic       core_ack = 1'b0, reti_pulse = 1'b0, psw_ep = 1'b0, psw_np = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_intc u_dut (.*);

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_OUT = 2'd2, OP_ACK = 2'd3;
  localparam int NV = 23;
  // {req tag, op, addr, data}; OP_OUT data = {req,0,vec[2:0],lvl[2:0]}
  localparam logic [21:0] TBL [NV] = '{
    {4'd1, OP_RD,  8'h10, 8'h40},   // R1 mask set after reset
    {4'd1, OP_RD,  8'hFA, 8'h00},   // R1 in-service clear
    {4'd1, OP_OUT, 8'h00, 8'h00},   // R1 no request
    {4'd2, OP_WR,  8'h10, 8'h85},
    {4'd2, OP_RD,  8'h10, 8'h85},   // R2 layout
    {4'd2, OP_RD,  8'h11, 8'h00},   // R2 odd address
    {4'd5, OP_OUT, 8'h00, 8'h85},   // R5 src0 lvl5
    {4'd5, OP_WR,  8'h16, 8'h82},
    {4'd5, OP_OUT, 8'h00, 8'h9A},   // R5 src3 lvl2 wins
    {4'd5, OP_WR,  8'h14, 8'h82},
    {4'd5, OP_OUT, 8'h00, 8'h92},   // R5 tie -> src2
    {4'd7, OP_ACK, 8'h00, 8'h00},
    {4'd7, OP_RD,  8'hFA, 8'h04},   // R7 level2 in service
    {4'd7, OP_RD,  8'h14, 8'h02},   // R7 flag cleared
    {4'd6, OP_OUT, 8'h00, 8'h00},   // R6 equal and lower blocked
    {4'd9, OP_WR,  8'hFA, 8'hFF},
    {4'd9, OP_RD,  8'hFA, 8'h04},   // R9 write ignored
    {4'd6, OP_WR,  8'h12, 8'h81},
    {4'd6, OP_OUT, 8'h00, 8'h89},   // R6 more urgent passes
    {4'd7, OP_ACK, 8'h00, 8'h00},
    {4'd7, OP_RD,  8'hFA, 8'h06},   // R7 nesting
    {4'd4, OP_WR,  8'h18, 8'hC0},
    {4'd4, OP_OUT, 8'h00, 8'h00}    // R4 masked prio0 not forwarded
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  function automatic logic [7:0] outs();
    return {core_req, 1'b0, core_vec, core_lvl};
  endfunction

  task automatic ret(input logic ep, input logic np);
    psw_ep = ep; psw_np = np; reti_pulse = 1'b1;
    tick();
    reti_pulse = 1'b0; psw_ep = 1'b0; psw_np = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    for (int k = 0; k < NV; k++) begin
      automatic logic [3:0] rq = TBL[k][21:18];
      automatic logic [1:0] op = TBL[k][17:16];
      automatic logic [7:0] a  = TBL[k][15:8];
      automatic logic [7:0] d  = TBL[k][7:0];
      automatic string tag = $sformatf("step %0d R%0d", k, rq);
      case (op)
        OP_WR:  wr(a, d);
        OP_RD:  rd(tag, a, d);
        OP_OUT: begin #1; chk(tag, outs(), d); end
        default: begin core_ack = 1'b1; tick(); core_ack = 1'b0; end
      endcase
    end
    // R8 return gated by status inputs
    ret(1'b1, 1'b0);
    rd("R8 ep held", 8'hFA, 8'h06);
    ret(1'b0, 1'b1);
    rd("R8 np held", 8'hFA, 8'h06);
    ret(1'b0, 1'b0);
    rd("R8 clears most urgent", 8'hFA, 8'h04);
    chk("R6 still blocked", outs(), 8'h00);
    ret(1'b0, 1'b0);
    rd("R8 clears last", 8'hFA, 8'h00);
    chk("R5 src3 after unblock", outs(), 8'h9A);
    // R3 pulse and bus write
    wr(8'h1A, 8'h00);
    rd("R3 written clear", 8'h1A, 8'h00);
    src_pulse[5] = 1'b1; tick(); src_pulse[5] = 1'b0;
    rd("R3 pulse sets flag", 8'h1A, 8'h80);
    chk("R5 src5 lvl0", outs(), 8'hA8);
    src_pulse[5] = 1'b1; wr(8'h1A, 8'h00); src_pulse[5] = 1'b0;
    rd("R3 pulse beats clear", 8'h1A, 8'h80);
    // R7 acknowledge without request
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    rd("R1 reset clears flag", 8'h1A, 8'h40);
    core_ack = 1'b1; tick(); core_ack = 1'b0;
    rd("R7 stray ack", 8'hFA, 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule